// File: doc/BRIEF.md
# Unaligned Vector Load-Left Unit

This unit carries out one load-left instruction for a processor with a 128-bit vector register file. It takes in an instruction word and decodes it in one of two layouts. The narrow layout names one of 32 vector registers. The wide layout names one of 128 vector registers, and its destination number is split across two fields. The two general-purpose operand values are supplied by the caller, who looks them up using register indices that the unit drives combinationally from the instruction word. The unit adds the two operands to form a 64-bit effective address. It issues one aligned 16-byte read to a synchronous memory port and waits for the response.

Memory is big-endian. The unit takes the bytes from the effective address up to the end of its 16-byte block and places them in the leftmost lanes of the result. The remaining lanes are filled with zero. The result is then written to the vector register file with a one-cycle write strobe. An instruction word that matches neither layout raises a one-cycle illegal flag and causes no memory read and no register write. Only one instruction is in flight at any time.

The sequencer has five states:
- IDLE: ready for an instruction.
- ISSUE: the memory request cycle.
- WAIT: waiting for the memory response.
- WRITE: the register write cycle.
- TRAP: the illegal-flag cycle.

Its transitions are:
- IDLE to ISSUE when a legal word is accepted.
- IDLE to TRAP when an illegal word is accepted.
- ISSUE to WAIT unconditionally.
- WAIT to WRITE when the response is valid.
- WRITE to IDLE unconditionally.
- TRAP to IDLE unconditionally.

Top module: `vldl_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, in_ready is 1 and mem_req, vr_we and ill_instr are 0.
- R2: The narrow layout is accepted when all of the following hold: in_instr[31:26] is 31, in_instr[10:1] is 775 and in_instr[0] is 0. Its destination is in_instr[25:21], its A field is in_instr[20:16] and its B field is in_instr[15:11].
- R3: The wide layout is accepted when all of the following hold: in_instr[31:26] is 4, in_instr[10:4] is 7'h60 and in_instr[1:0] is 2'b11. Its A and B fields sit where they do in the narrow layout. Its 7-bit destination is {in_instr[3:2], in_instr[25:21]}.
- R4: The effective address is computed as A + B, modulo 2^64. A is zero when the A field is 0, whatever value ra_data carries; otherwise A is ra_data. B is always rb_data.
- R5: In the cycle after a legal word is accepted, mem_req is 1 for exactly one cycle. mem_addr then equals the effective address with its low 4 bits cleared.
- R6: Byte lane k of mem_rdata, held in bits [127-8k:120-8k], is the memory byte at block base + k. Let off be the effective address modulo 16. Result lane i is set to block lane off+i for i < 16-off, and to zero otherwise. So from 1 to 16 bytes are loaded.
- R7: vr_we is 1 for exactly one cycle, in the cycle after mem_rvalid is seen while waiting. vr_waddr and vr_wdata carry the decoded destination and the result in that cycle.
- R8: A word matching neither layout sets ill_instr for one cycle, in the cycle after acceptance. It causes no mem_req and no vr_we.
- R9: in_ready is 0 from the cycle after acceptance until the unit returns to IDLE. A mem_rvalid arriving while the unit is idle has no effect.
- R10: ra_idx and rb_idx follow in_instr[20:16] and in_instr[15:11] combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can accept a word |
| in_instr | input | 32 | Instruction word |
| ra_idx | output | 5 | A register index for the register-file read |
| rb_idx | output | 5 | B register index for the register-file read |
| ra_data | input | XLEN | Value of register ra_idx |
| rb_data | input | XLEN | Value of register rb_idx |
| mem_req | output | 1 | Aligned block read request |
| mem_addr | output | XLEN | Block-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8*VBYTES | Big-endian block contents |
| vr_we | output | 1 | Vector register write strobe |
| vr_waddr | output | 7 | Destination vector register |
| vr_wdata | output | 8*VBYTES | Left-justified, zero-filled result |
| ill_instr | output | 1 | Unrecognised instruction pulse |

## Verification
The bench builds the unit with its defaults: a 64-bit address and 16-byte vectors. These values bring the following cases within reach:
- every load length from a single byte (offset 15) to a full vector (offset 0);
- address wrap past 2^64;
- destinations at both ends of the 128-entry space, including values whose high field is nonzero.

A 64-bit address also lets an A operand with the top bits set show that the zero substitution for field 0 and the carry out of bit 63 are handled. Memory latencies of one to three cycles exercise how long the unit stays in WAIT.

// File: rtl/vldl_pkg.sv
package vldl_pkg;

    localparam int INSTR_W  = 32;
    localparam int GIDX_W   = 5;
    localparam int VIDX_W   = 7;

    localparam logic [5:0] OPC_NARROW = 6'd31;
    localparam logic [9:0] XO_NARROW  = 10'd775;
    localparam logic [5:0] OPC_WIDE   = 6'd4;
    localparam logic [6:0] XO_WIDE    = 7'h60;
    localparam logic [1:0] WIDE_TAIL  = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE,
        ST_TRAP
    } ldl_state_e;

    typedef struct packed {
        logic              legal;
        logic [VIDX_W-1:0] vd;
        logic [GIDX_W-1:0] ra;
        logic [GIDX_W-1:0] rb;
    } ldl_dec_t;

endpackage

// File: rtl/vldl_decode.sv
module vldl_decode
    import vldl_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ldl_dec_t           dec
);

    logic [5:0] opc;
    logic       narrow_hit;
    logic       wide_hit;

    assign opc = instr[31:26];

    // narrow layout: 10-bit extended code, record bit must be clear
    assign narrow_hit = (opc == OPC_NARROW) && (instr[10:1] == XO_NARROW) && !instr[0];
    // wide layout: 7-bit extended code, reserved tail bits fixed
    assign wide_hit   = (opc == OPC_WIDE) && (instr[10:4] == XO_WIDE) && (instr[1:0] == WIDE_TAIL);

    always_comb begin
        dec.legal = narrow_hit || wide_hit;
        dec.ra    = instr[20:16];
        dec.rb    = instr[15:11];
        if (wide_hit) begin
            dec.vd = {instr[3:2], instr[25:21]};
        end else begin
            dec.vd = {2'b00, instr[25:21]};
        end
    end

endmodule

// File: rtl/vldl_agen.sv
module vldl_agen #(
    parameter int XLEN = 64
) (
    input  logic            ra_is_zero,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] rb_val,
    output logic [XLEN-1:0] ea
);

    logic [XLEN-1:0] base_op;

    assign base_op = ra_is_zero ? '0 : ra_val;
    assign ea      = base_op + rb_val;   // wraps modulo 2^XLEN

endmodule

// File: rtl/vldl_align.sv
module vldl_align #(
    parameter  int VBYTES = 16,
    localparam int OFF_W  = $clog2(VBYTES),
    localparam int VEC_W  = VBYTES * 8
) (
    input  logic [VEC_W-1:0] blk,
    input  logic [OFF_W-1:0] off,
    output logic [VEC_W-1:0] res
);

    logic [7:0] blk_b [VBYTES];

    for (genvar k = 0; k < VBYTES; k++) begin : g_split
        assign blk_b[k] = blk[VEC_W-1-8*k -: 8];
    end

    // lane i takes block byte off+i; a carry into bit OFF_W means past the block
    for (genvar i = 0; i < VBYTES; i++) begin : g_lane
        logic [OFF_W:0] src;
        assign src = {1'b0, off} + (OFF_W+1)'(i);
        assign res[VEC_W-1-8*i -: 8] = src[OFF_W] ? 8'h00 : blk_b[src[OFF_W-1:0]];
    end

endmodule

// File: rtl/vldl_unit.sv
module vldl_unit
    import vldl_pkg::*;
#(
    parameter  int XLEN   = 64,
    parameter  int VBYTES = 16,
    localparam int VEC_W  = VBYTES * 8,
    localparam int OFF_W  = $clog2(VBYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSTR_W-1:0] in_instr,
    output logic [GIDX_W-1:0]  ra_idx,
    output logic [GIDX_W-1:0]  rb_idx,
    input  logic [XLEN-1:0]    ra_data,
    input  logic [XLEN-1:0]    rb_data,
    output logic               mem_req,
    output logic [XLEN-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [VEC_W-1:0]   mem_rdata,
    output logic               vr_we,
    output logic [VIDX_W-1:0]  vr_waddr,
    output logic [VEC_W-1:0]   vr_wdata,
    output logic               ill_instr
);

    ldl_state_e         state_q, state_d;
    ldl_dec_t           dec;
    logic [XLEN-1:0]    ea_next;
    logic [XLEN-1:0]    ea_q;
    logic [VIDX_W-1:0]  vd_q;
    logic [VEC_W-1:0]   aligned;
    logic [VEC_W-1:0]   data_q;
    logic               accept;

    vldl_decode u_decode (
        .instr (in_instr),
        .dec   (dec)
    );

    vldl_agen #(.XLEN(XLEN)) u_agen (
        .ra_is_zero (dec.ra == '0),
        .ra_val     (ra_data),
        .rb_val     (rb_data),
        .ea         (ea_next)
    );

    vldl_align #(.VBYTES(VBYTES)) u_align (
        .blk (mem_rdata),
        .off (ea_q[OFF_W-1:0]),
        .res (aligned)
    );

    assign ra_idx = dec.ra;
    assign rb_idx = dec.rb;
    assign accept = in_valid && in_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = dec.legal ? ST_ISSUE : ST_TRAP;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_rvalid) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            ST_TRAP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operand and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            vd_q   <= '0;
            data_q <= '0;
        end else begin
            if (accept && dec.legal) begin
                ea_q <= ea_next;
                vd_q <= dec.vd;
            end
            if (state_q == ST_WAIT && mem_rvalid) begin
                data_q <= aligned;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        vr_we     = 1'b0;
        ill_instr = 1'b0;
        unique case (state_q)
            ST_IDLE:  in_ready  = 1'b1;
            ST_ISSUE: mem_req   = 1'b1;
            ST_WAIT:  ;
            ST_WRITE: vr_we     = 1'b1;
            ST_TRAP:  ill_instr = 1'b1;
            default:  ;
        endcase
        mem_addr = {ea_q[XLEN-1:OFF_W], {OFF_W{1'b0}}};
        vr_waddr = vd_q;
        vr_wdata = data_q;
    end

    p_req_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    p_req_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(in_valid && in_ready));

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_we_after_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |-> $past(mem_rvalid));

    p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |=> !vr_we);

    p_ill_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ill_instr |-> (!mem_req && !vr_we));

    p_ill_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ill_instr |-> $past(in_valid && in_ready));

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || vr_we || ill_instr) |-> !in_ready);

    p_one_hot_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, vr_we, ill_instr}));

endmodule

// File: tb/vldl_unit_tb.sv
`timescale 1ns/1ps
module vldl_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_instr;
    logic [4:0]   ra_idx, rb_idx;
    logic [63:0]  ra_data, rb_data;
    logic         mem_req;
    logic [63:0]  mem_addr;
    logic         mem_rvalid;
    logic [127:0] mem_rdata;
    logic         vr_we;
    logic [6:0]   vr_waddr;
    logic [127:0] vr_wdata;
    logic         ill_instr;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    vldl_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
        .ra_idx(ra_idx), .rb_idx(rb_idx), .ra_data(ra_data), .rb_data(rb_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .vr_we(vr_we), .vr_waddr(vr_waddr), .vr_wdata(vr_wdata), .ill_instr(ill_instr)
    );

    function automatic logic [31:0] mk_narrow(input logic [4:0] vd, input logic [4:0] ra,
                                              input logic [4:0] rb, input logic [9:0] xo,
                                              input logic rc);
        return {6'd31, vd, ra, rb, xo, rc};
    endfunction

    function automatic logic [31:0] mk_wide(input logic [5:0] opc, input logic [6:0] vd,
                                            input logic [4:0] ra, input logic [4:0] rb,
                                            input logic [6:0] xo, input logic [1:0] tail);
        return {opc, vd[4:0], ra, rb, xo, vd[6:5], tail};
    endfunction

    // modelled memory contents
    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [127:0] block_at(input logic [63:0] base);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) r[127-8*k -: 8] = mem_byte(base + 64'(k));
        return r;
    endfunction

    function automatic logic [127:0] expect_left(input logic [63:0] ea);
        logic [127:0] r;
        int off;
        off = int'(ea[3:0]);
        for (int i = 0; i < 16; i++)
            r[127-8*i -: 8] = (i < 16 - off) ? mem_byte(ea + 64'(i)) : 8'h00;
        return r;
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] ea;
        logic [6:0]  vd;
        logic        legal;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R2 full 16-byte load, offset 0
        '{mk_narrow(5'd3, 5'd5, 5'd6, 10'd775, 1'b0), 64'h1000, 64'h20, 64'h1020, 7'd3, 1'b1},
        // R2 offset 5
        '{mk_narrow(5'd31, 5'd2, 5'd7, 10'd775, 1'b0), 64'h2000, 64'h5, 64'h2005, 7'd31, 1'b1},
        // R4 A field 0 ignores ra_data; R6 single byte at offset 15
        '{mk_narrow(5'd0, 5'd0, 5'd9, 10'd775, 1'b0), 64'hDEAD_0000, 64'h300F, 64'h300F, 7'd0, 1'b1},
        // R3 top destination
        '{mk_wide(6'd4, 7'd127, 5'd1, 5'd1, 7'h60, 2'b11), 64'h4000, 64'h8, 64'h4008, 7'd127, 1'b1},
        // R3 high field 2'b10, R4 A field 0
        '{mk_wide(6'd4, 7'h45, 5'd0, 5'd3, 7'h60, 2'b11), 64'h99, 64'h5001, 64'h5001, 7'h45, 1'b1},
        // R4 wrap modulo 2^64
        '{mk_narrow(5'd7, 5'd4, 5'd8, 10'd775, 1'b0), 64'hFFFF_FFFF_FFFF_FFF8, 64'h13, 64'h000B, 7'd7, 1'b1},
        // R8 wrong extended code
        '{mk_narrow(5'd1, 5'd1, 5'd1, 10'd774, 1'b0), 64'h0, 64'h0, 64'h0, 7'd0, 1'b0},
        // R8 record bit set
        '{mk_narrow(5'd1, 5'd1, 5'd1, 10'd775, 1'b1), 64'h0, 64'h0, 64'h0, 7'd0, 1'b0},
        // R8 wide layout with reserved tail not 2'b11
        '{mk_wide(6'd4, 7'd9, 5'd1, 5'd1, 7'h60, 2'b00), 64'h0, 64'h0, 64'h0, 7'd0, 1'b0},
        // R8 wide opcode with wrong extended code
        '{mk_wide(6'd4, 7'd9, 5'd1, 5'd1, 7'h61, 2'b11), 64'h0, 64'h0, 64'h0, 7'd0, 1'b0},
        // R3 high field 2'b01, B field 0 is an ordinary register
        '{mk_wide(6'd4, 7'h20, 5'd10, 5'd0, 7'h60, 2'b11), 64'h6000, 64'h7, 64'h6007, 7'h20, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int lat);
        logic [63:0] base;
        base = {v.ea[63:4], 4'h0};
        in_instr = v.ins; ra_data = v.a; rb_data = v.b; in_valid = 1'b1;
        #1;
        chk(ra_idx == v.ins[20:16] && rb_idx == v.ins[15:11], "R10 idx", {ra_idx, rb_idx}, {v.ins[20:16], v.ins[15:11]});
        chk(in_ready == 1'b1, "R9 ready idle", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        if (v.legal) begin
            chk(mem_req == 1'b1 && in_ready == 1'b0, "R5 req/R9 busy", {mem_req, in_ready}, 2'b10);
            chk(mem_addr == base, "R4 R5 address", mem_addr, base);
            chk(ill_instr == 1'b0, "R8 no flag on legal", ill_instr, 0);
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                chk(mem_req == 1'b0 && vr_we == 1'b0, "R5 single req", {mem_req, vr_we}, 0);
            end
            mem_rvalid = 1'b1; mem_rdata = block_at(base);
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = '0;
            chk(vr_we == 1'b1, "R7 write strobe", vr_we, 1);
            chk(vr_waddr == v.vd, "R2 R3 destination", vr_waddr, v.vd);
            chk(vr_wdata == expect_left(v.ea), "R6 data", vr_wdata, expect_left(v.ea));
            @(negedge clk);
            chk(vr_we == 1'b0 && in_ready == 1'b1, "R7 pulse/R9 ready", {vr_we, in_ready}, 2'b01);
        end else begin
            chk(ill_instr == 1'b1 && mem_req == 1'b0 && in_ready == 1'b0, "R8 flag", {ill_instr, mem_req, in_ready}, 3'b100);
            @(negedge clk);
            chk(ill_instr == 1'b0 && mem_req == 1'b0 && vr_we == 1'b0 && in_ready == 1'b1,
                "R8 quiet", {ill_instr, mem_req, vr_we, in_ready}, 4'b0001);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; ra_data = '0; rb_data = '0;
        mem_rvalid = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1 && mem_req == 1'b0 && vr_we == 1'b0 && ill_instr == 1'b0,
            "R1 reset", {in_ready, mem_req, vr_we, ill_instr}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && mem_req == 1'b0 && vr_we == 1'b0 && ill_instr == 1'b0,
            "R1 after reset", {in_ready, mem_req, vr_we, ill_instr}, 4'b1000);

        for (int n = 0; n < NV; n++) run_vec(VECS[n], (n % 3) + 1);

        // R9 stray response while idle has no effect
        mem_rvalid = 1'b1; mem_rdata = {16{8'hFF}};
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(vr_we == 1'b0 && mem_req == 1'b0 && in_ready == 1'b1, "R9 stray rvalid", {vr_we, mem_req, in_ready}, 3'b001);
        @(negedge clk);
        chk(vr_we == 1'b0 && in_ready == 1'b1, "R9 stray rvalid later", {vr_we, in_ready}, 2'b01);

        // R6 every offset within one block
        for (int o = 0; o < 16; o++) begin
            vec_t v;
            v = '{mk_narrow(5'd12, 5'd3, 5'd4, 10'd775, 1'b0), 64'h8_0000, 64'(o) + 64'h30, 64'h8_0030 + 64'(o), 7'd12, 1'b1};
            run_vec(v, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule